// File: doc/BRIEF.md
# Branch Target Buffer

The block is a small direct-mapped cache that the fetch stage uses to predict the next fetch address. It looks up the current program counter in the same cycle, before the instruction has been decoded. Each entry holds the complete address of a control-transfer instruction as its tag and the address it last jumped to. Because the whole PC is compared against the tag, a hit is enough to redirect fetch without decoding the instruction. On a miss the predicted next address is the next sequential instruction.

The execute stage writes entries back once a branch or jump has resolved and its outcome and target are known. A taken control instruction allocates its slot, replacing whatever the slot held. A not-taken control instruction that currently hits removes its entry. Instructions that are not control transfers never touch the table. The lookup path is purely combinational over the stored state, so an update in a given cycle becomes visible to lookups from the following cycle onward.

Top module: `btb_predictor`

## Requirements
- R1: Reset (active-low `rst_n`, asynchronous) invalidates every entry, so every lookup misses until a new entry is allocated.
- R2: A lookup hits only when the slot it selects is valid and that slot's stored tag equals the complete lookup PC. A PC that shares the slot but differs in any other bit misses.
- R3: On a hit, `lk_target` and `lk_next_pc` both equal the stored target.
- R4: On a miss, `lk_target` is zero and `lk_next_pc` is `lk_pc + INSN_BYTES` (4 by default).
- R5: An update with `up_valid`, `up_is_ctrl` and `up_taken` all high writes `up_pc` as the tag and `up_target` as the target into its slot, replacing any previous occupant. Lookups see the new entry from the next cycle.
- R6: An update with `up_valid` and `up_is_ctrl` high and `up_taken` low, whose `up_pc` currently hits, invalidates that entry from the next cycle.
- R7: A not-taken control update whose `up_pc` does not hit leaves the table unchanged, including any other PC held in the same slot.
- R8: An update with `up_is_ctrl` low, or with `up_valid` low, never changes the table.
- R9: When a lookup and an update touch the same slot in the same cycle, the lookup returns the contents from before the update.
- R10: The slot index is `pc[OFFSET_W +: IDX_W]` (bits 5:2 by default, 16 slots). PCs that differ in those bits occupy independent slots.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_pc | input | ADDR_W | Fetch PC being looked up |
| lk_hit | output | 1 | The lookup PC is held in the table |
| lk_target | output | ADDR_W | Stored target on a hit, zero otherwise |
| lk_next_pc | output | ADDR_W | Predicted next fetch address |
| up_valid | input | 1 | A resolved instruction is being reported this cycle |
| up_pc | input | ADDR_W | PC of the resolved instruction |
| up_target | input | ADDR_W | Resolved target address |
| up_taken | input | 1 | The resolved instruction transferred control |
| up_is_ctrl | input | 1 | The resolved instruction is a branch or jump |

## Verification
The properties assume that reset is asserted from time zero and that at most one resolution arrives per cycle. They also assume that the update fields are only meaningful while `up_valid` is high, and that PCs are aligned to the instruction size. The stimulus draws aligned PCs from a small pool of three upper-address groups spread over all slots, so aliasing, overwrites and invalidations occur often. The update flags are randomised independently, and reset is applied again in the middle of the run to confirm that entries written earlier are dropped.

// File: rtl/btb_predictor.sv
module btb_predictor #(
  parameter int ADDR_W     = 32,
  parameter int IDX_W      = 4,
  parameter int OFFSET_W   = 2,
  parameter int INSN_BYTES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] lk_pc,
  output logic              lk_hit,
  output logic [ADDR_W-1:0] lk_target,
  output logic [ADDR_W-1:0] lk_next_pc,
  input  logic              up_valid,
  input  logic [ADDR_W-1:0] up_pc,
  input  logic [ADDR_W-1:0] up_target,
  input  logic              up_taken,
  input  logic              up_is_ctrl
);
  localparam int ENTRIES = 1 << IDX_W;

  logic [ENTRIES-1:0] vld_q;
  logic [ADDR_W-1:0]  tag_q [ENTRIES];
  logic [ADDR_W-1:0]  tgt_q [ENTRIES];

  logic [IDX_W-1:0] lk_idx, up_idx;
  logic             up_match, do_alloc, do_kill;

  assign lk_idx = lk_pc[OFFSET_W +: IDX_W];
  assign up_idx = up_pc[OFFSET_W +: IDX_W];

  assign lk_hit     = vld_q[lk_idx] && (tag_q[lk_idx] == lk_pc);
  assign lk_target  = lk_hit ? tgt_q[lk_idx] : '0;
  assign lk_next_pc = lk_hit ? tgt_q[lk_idx] : lk_pc + ADDR_W'(INSN_BYTES);

  assign up_match = vld_q[up_idx] && (tag_q[up_idx] == up_pc);
  assign do_alloc = up_valid && up_is_ctrl && up_taken;
  assign do_kill  = up_valid && up_is_ctrl && !up_taken && up_match;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        vld_q <= '0;
    else if (do_alloc) vld_q[up_idx] <= 1'b1;
    else if (do_kill)  vld_q[up_idx] <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (do_alloc) begin
      tag_q[up_idx] <= up_pc;
      tgt_q[up_idx] <= up_target;
    end
  end
endmodule

// File: rtl/btb_predictor_chk.sv
module btb_predictor_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] lk_pc,
  input logic              lk_hit,
  input logic [ADDR_W-1:0] lk_target,
  input logic [ADDR_W-1:0] lk_next_pc,
  input logic              up_valid,
  input logic [ADDR_W-1:0] up_pc,
  input logic [ADDR_W-1:0] up_target,
  input logic              up_taken,
  input logic              up_is_ctrl
);
  logic was_rst;
  always_ff @(posedge clk) was_rst <= !rst_n;

  assert_empty_after_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
    was_rst |-> !lk_hit);

  assert_hit_redirects_R3: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> lk_next_pc == lk_target);

  assert_alloc_visible_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (up_valid && up_is_ctrl && up_taken) |=>
      (lk_pc != $past(up_pc)) || (lk_hit && lk_target == $past(up_target)));

  assert_not_taken_gone_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (up_valid && up_is_ctrl && !up_taken) |=>
      (lk_pc != $past(up_pc)) || !lk_hit);

  assert_non_ctrl_inert_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!up_valid || !up_is_ctrl) |=>
      (lk_pc != $past(lk_pc)) ||
      (lk_hit == $past(lk_hit) && lk_target == $past(lk_target)));
endmodule

bind btb_predictor btb_predictor_chk #(.ADDR_W(ADDR_W)) chk_i (.*);

// File: tb/btb_predictor_tb_top.sv
module btb_predictor_tb_top;
  localparam int AW = 32;
  localparam int IW = 4;
  localparam int OW = 2;
  localparam int IB = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [AW-1:0] lk_pc = '0, up_pc = '0, up_target = '0;
  logic up_valid = 1'b0, up_taken = 1'b0, up_is_ctrl = 1'b0;
  logic lk_hit;
  logic [AW-1:0] lk_target, lk_next_pc;

  int checks = 0;
  int errors = 0;
  logic [AW-1:0] model [logic [AW-1:0]];

  always #2 clk = ~clk;

  btb_predictor #(.ADDR_W(AW), .IDX_W(IW), .OFFSET_W(OW), .INSN_BYTES(IB)) dut_i (
    .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .lk_hit(lk_hit), .lk_target(lk_target),
    .lk_next_pc(lk_next_pc), .up_valid(up_valid), .up_pc(up_pc), .up_target(up_target),
    .up_taken(up_taken), .up_is_ctrl(up_is_ctrl));

  function automatic int slot_of(logic [AW-1:0] pc);
    return int'((pc >> OW) & ((1 << IW) - 1));
  endfunction

  task automatic model_update(logic v, logic [AW-1:0] pc, logic [AW-1:0] tg, logic tk, logic ct);
    logic [AW-1:0] drop[$];
    if (!v || !ct) return;
    if (tk) begin
      foreach (model[k]) if (slot_of(k) == slot_of(pc)) drop.push_back(k);
      foreach (drop[i]) model.delete(drop[i]);
      model[pc] = tg;
    end else if (model.exists(pc)) begin
      model.delete(pc);
    end
  endtask

  task automatic step(string req, logic [AW-1:0] lpc, logic v, logic [AW-1:0] upc,
                      logic [AW-1:0] utg, logic tk, logic ct);
    logic eh;
    logic [AW-1:0] et, en;
    string tag;
    @(negedge clk);
    lk_pc = lpc; up_valid = v; up_pc = upc; up_target = utg; up_taken = tk; up_is_ctrl = ct;
    #1;
    eh = model.exists(lpc);
    et = eh ? model[lpc] : '0;
    en = eh ? et : lpc + IB;
    tag = (req != "") ? req : (eh ? "R3" : "R4");
    checks++;
    if (lk_hit !== eh || lk_target !== et || lk_next_pc !== en) begin
      errors++;
      $display("FAIL %s pc=%h: hit=%b target=%h next=%h expected hit=%b target=%h next=%h",
               tag, lpc, lk_hit, lk_target, lk_next_pc, eh, et, en);
    end
    @(posedge clk);
    model_update(v, upc, utg, tk, ct);
  endtask

  task automatic look(string req, logic [AW-1:0] lpc);
    step(req, lpc, 1'b0, '0, '0, 1'b0, 1'b0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    up_valid = 1'b0;
    model.delete();
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    do_reset();
    look("R1", 32'h100);
    look("R4", 32'h3FC);
    step("R9", 32'h100, 1, 32'h100, 32'h2000, 1, 1);
    look("R5", 32'h100);
    look("R3", 32'h100);
    look("R2", 32'h140);
    look("R2", 32'h101);
    step("R10", 32'h104, 1, 32'h104, 32'h3000, 1, 1);
    look("R10", 32'h104);
    look("R10", 32'h100);
    step("R8", 32'h108, 1, 32'h108, 32'h4000, 1, 0);
    look("R8", 32'h108);
    step("R8", 32'h100, 1, 32'h100, 32'h5000, 1, 0);
    look("R8", 32'h100);
    step("R8", 32'h100, 0, 32'h100, 32'h5000, 1, 1);
    look("R8", 32'h100);
    step("R7", 32'h100, 1, 32'h140, 32'h0, 0, 1);
    look("R7", 32'h100);
    step("R5", 32'h140, 1, 32'h140, 32'h6000, 1, 1);
    look("R5", 32'h140);
    look("R2", 32'h100);
    step("R9", 32'h140, 1, 32'h140, 32'h0, 0, 1);
    look("R6", 32'h140);
    look("R6", 32'h104);

    for (int n = 0; n < 3000; n++) begin
      logic [AW-1:0] lp, upc;
      lp  = 32'h1000 + ($urandom % 3) * 64 + ($urandom % 16) * 4;
      upc = 32'h1000 + ($urandom % 3) * 64 + ($urandom % 16) * 4;
      if (($urandom % 4) == 0) upc = lp;
      step("", lp, ($urandom % 2) == 0, upc, $urandom & 32'hFFFF_FFFC,
           ($urandom % 10) < 6, ($urandom % 10) < 7);
    end

    step("R5", 32'h1000, 1, 32'h1000, 32'h8000, 1, 1);
    look("R3", 32'h1000);
    do_reset();
    look("R1", 32'h1000);
    look("R1", 32'h104);
    for (int s = 0; s < 16; s++) look("R1", 32'h1040 + s * 4);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule